// File: doc/BRIEF.md
# Multi-mode operand fetch unit

This block finds the operand of a load-accumulator instruction and writes it into the accumulator. The instruction occupies two consecutive words. The opcode word sits at the program counter value, and the address word follows it. When the caller pulses `start`, the unit samples several inputs in that same cycle:

- a 3-bit addressing-mode code,
- the address word,
- the program counter,
- a general register and an index register.

It then runs the sequence of memory reads that the mode needs, which is zero, one or two reads. Memory is reached through a plain synchronous read port with one cycle of latency. The unit reports completion with a one-cycle `done` pulse, in the same cycle that the new accumulator value appears.

Seven modes are supported: direct, indirect, register, register-indirect, immediate, PC-relative and indexed. All address arithmetic is done in the address width and wraps around the address space. The eighth mode code is illegal. It produces a one-cycle `err` pulse and leaves the accumulator untouched.

Top module: `lda_operand_unit`

## Requirements
- R1: After a synchronous active-low reset, `acc` is 0 and `done`, `err` and `mem_rd` are all 0.
- R2: Mode code 0 (direct) loads `acc` with M[addr]. It makes exactly one read, and `done` is seen 3 cycles after the cycle in which `start` was sampled.
- R3: Mode code 1 (indirect) loads `acc` with M[P], where P is the low ADDR_W bits of M[addr]. It makes exactly two reads, and `done` is seen 5 cycles after the start cycle.
- R4: Mode code 2 (register) loads `acc` with the full register value `reg_r`. It makes no memory read, and `done` is seen 1 cycle after the start cycle.
- R5: Mode code 3 (register-indirect) loads `acc` with M[reg_r mod 2^ADDR_W]. It makes one read, with a latency of 3.
- R6: Mode code 4 (immediate) loads `acc` with the word at pc+1, which is the address word itself. It makes one read, with a latency of 3.
- R7: Mode code 5 (relative) loads `acc` with M[pc+2+addr]. The addr field is treated as a two's-complement offset and the sum wraps modulo 2^ADDR_W. It makes one read, with a latency of 3.
- R8: Mode code 6 (indexed) loads `acc` with M[addr+reg_x], with the sum wrapping modulo 2^ADDR_W. It makes one read, with a latency of 3.
- R9: Mode code 7 pulses `err` for one cycle, 1 cycle after the start cycle. It gives no `done`, makes no memory read and leaves `acc` unchanged.
- R10: A `start` pulse that arrives while an operation is still in progress is ignored. It does not change the result, the latency or the number of reads, and it does not cause any later `done`.
- R11: `acc` changes only in a cycle where `done` is 1. Each read request lasts exactly one cycle.
- R12: All inputs that define an operation are sampled in the start cycle. Changing them afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; honoured only when idle |
| mode | input | 3 | Addressing-mode code |
| addr_fld | input | ADDR_W | Address word of the instruction |
| pc | input | ADDR_W | Address of the opcode word |
| reg_r | input | DATA_W | General register |
| reg_x | input | ADDR_W | Index register |
| mem_rd | output | 1 | Read request, one cycle |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after the request |
| acc | output | DATA_W | Accumulator |
| done | output | 1 | Accumulator written this cycle |
| err | output | 1 | Illegal mode code seen |

## Verification
The bench builds the unit with the defaults ADDR_W=12 and DATA_W=16. With these widths, address sums can easily cross the top of the 4096-word space, so both wrap and negative relative offsets can be reached. Memory words are four bits wider than an address, so the indirect pointer and the register-indirect address must drop their upper bits. A hashed memory content function makes a wrong effective address show up as a wrong accumulator value.

// File: rtl/lda_operand_pkg.sv
// Shared types for the operand fetch unit.
// Assumes a 3-bit mode code; the code values are decoded in ofu_ea_calc.
package lda_operand_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_INDIR   = 3'd1,
        AM_REG     = 3'd2,
        AM_REGIND  = 3'd3,
        AM_IMM     = 3'd4,
        AM_REL     = 3'd5,
        AM_IDX     = 3'd6,
        AM_BAD     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ofu_ea_calc.sv
// Effective-address calculator.
// Purely combinational. Turns the mode code and the live instruction inputs
// into a first read address, plus flags that say how many reads are needed.
// Assumes all sums wrap modulo 2^ADDR_W.
module ofu_ea_calc
    import lda_operand_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] r_i,
    input  logic [ADDR_W-1:0] x_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              use_mem_o,
    output logic              two_hop_o,
    output logic              illegal_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    amode_e m;
    assign m = amode_e'(mode_i);

    // Select the first address and the read profile for each mode.
    always_comb begin
        ea_o      = addr_i;
        use_mem_o = 1'b1;
        two_hop_o = 1'b0;
        illegal_o = 1'b0;
        case (m)
            AM_DIRECT: ea_o = addr_i;
            AM_INDIR:  begin ea_o = addr_i; two_hop_o = 1'b1; end
            AM_REG:    use_mem_o = 1'b0;
            AM_REGIND: ea_o = r_i;
            AM_IMM:    ea_o = pc_i + ONE;
            AM_REL:    ea_o = pc_i + TWO + addr_i;
            AM_IDX:    ea_o = addr_i + x_i;
            default:   begin use_mem_o = 1'b0; illegal_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ofu_seq.sv
// Read sequencer and accumulator.
// Issues one or two single-cycle reads and writes the accumulator, or handles
// the no-read and illegal cases in the start cycle. Assumes memory data is
// valid exactly one cycle after the request cycle.
module ofu_seq
    import lda_operand_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              use_mem_i,
    input  logic              two_hop_i,
    input  logic              illegal_i,
    input  logic [DATA_W-1:0] r_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              done_o,
    output logic              err_o
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] ea_q;
    logic              hop_q;

    // State, address latch, accumulator and the completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
            hop_q   <= 1'b0;
            acc_o   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    if (illegal_i) begin
                        err_o <= 1'b1;
                    end else if (!use_mem_i) begin
                        acc_o  <= r_i;
                        done_o <= 1'b1;
                    end else begin
                        ea_q    <= ea_i;
                        hop_q   <= two_hop_i;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: state_q <= ST_RESP;
                ST_RESP: begin
                    if (hop_q) begin
                        ea_q    <= mem_rdata_i[ADDR_W-1:0];
                        hop_q   <= 1'b0;
                        state_q <= ST_REQ;
                    end else begin
                        acc_o   <= mem_rdata_i;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the read port from the latched address.
    assign mem_rd_o   = (state_q == ST_REQ);
    assign mem_addr_o = ea_q;

    AST_ACC_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(acc_o));                                   // R11
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);                                       // R11
    AST_ERR_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(acc_o));                                     // R9
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);                                            // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == ST_REQ) |=> (state_q == ST_RESP));      // R10

endmodule

// File: rtl/lda_operand_unit.sv
// Top of the multi-mode operand fetch unit.
// Connects the effective-address calculator to the read sequencer.
// Assumes DATA_W >= ADDR_W, so a memory word can hold a pointer.
module lda_operand_unit
    import lda_operand_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] reg_r,
    input  logic [ADDR_W-1:0] reg_x,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic              done,
    output logic              err
);

    logic [ADDR_W-1:0] ea;
    logic              use_mem;
    logic              two_hop;
    logic              illegal;

    ofu_ea_calc #(.ADDR_W(ADDR_W)) u_ea (
        .mode_i    (mode),
        .addr_i    (addr_fld),
        .pc_i      (pc),
        .r_i       (reg_r[ADDR_W-1:0]),
        .x_i       (reg_x),
        .ea_o      (ea),
        .use_mem_o (use_mem),
        .two_hop_o (two_hop),
        .illegal_o (illegal)
    );

    ofu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .ea_i        (ea),
        .use_mem_i   (use_mem),
        .two_hop_i   (two_hop),
        .illegal_i   (illegal),
        .r_i         (reg_r),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .acc_o       (acc),
        .done_o      (done),
        .err_o       (err)
    );

endmodule

// File: tb/lda_operand_unit_test.sv
module lda_operand_unit_test;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [AW-1:0] addr_fld = '0;
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] reg_r = '0;
    logic [AW-1:0] reg_x = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] acc;
    logic          done;
    logic          err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reads = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_acc = '0;

    always #4 clk = ~clk;

    lda_operand_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_fld(addr_fld), .pc(pc), .reg_r(reg_r), .reg_x(reg_x),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .acc(acc), .done(done), .err(err)
    );

    // Memory contents: a hash of the address
    function automatic logic [DW-1:0] memf(input logic [AW-1:0] q);
        logic [31:0] t;
        t = 32'(q) * 32'd40503 + 32'd7919;
        return t[DW-1:0] ^ t[31:16];
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= memf(mem_addr);
            n_reads = n_reads + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] m, input logic [AW-1:0] a,
                          input logic [AW-1:0] p, input logic [DW-1:0] r,
                          input logic [AW-1:0] x, input bit poke);
        logic [AW-1:0] ea;
        logic [DW-1:0] expv;
        int exp_lat;
        int exp_rd;
        int cyc;
        int rd0;
        string rq;
        rq = req_of(m);
        case (m)
            3'd0: ea = a;
            3'd1: ea = memf(a);
            3'd3: ea = r[AW-1:0];
            3'd4: ea = p + AW'(1);
            3'd5: ea = p + AW'(2) + a;
            3'd6: ea = a + x;
            default: ea = '0;
        endcase
        if (m == 3'd2) begin
            expv = r; exp_lat = 1; exp_rd = 0;
        end else if (m == 3'd7) begin
            expv = exp_acc; exp_lat = 1; exp_rd = 0;
        end else begin
            expv = memf(ea);
            exp_lat = (m == 3'd1) ? 5 : 3;
            exp_rd  = (m == 3'd1) ? 2 : 1;
        end
        @(negedge clk);
        mode = m; addr_fld = a; pc = p; reg_r = r; reg_x = x; start = 1'b1;
        n_reads = 0;
        @(negedge clk);
        start = 1'b0;
        // R12: scramble the instruction inputs after the start cycle
        mode = 3'($urandom); addr_fld = AW'($urandom); pc = AW'($urandom);
        reg_r = DW'($urandom); reg_x = AW'($urandom);
        cyc = 1;
        while (!done && !err && cyc < 12) begin
            if (poke && cyc == 1) begin
                start = 1'b1; mode = 3'd2; reg_r = ~expv;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk({rq, " acc (R12)"}, 32'(acc), 32'(expv));
        chk({rq, " latency"}, 32'(cyc), 32'(exp_lat));
        chk({rq, " read count"}, 32'(n_reads), 32'(exp_rd));
        chk({rq, " err flag"}, 32'(err), (m == 3'd7) ? 32'd1 : 32'd0);
        chk({rq, " done flag"}, 32'(done), (m == 3'd7) ? 32'd0 : 32'd1);
        exp_acc = expv;
        if (poke || m == 3'd7) begin
            rd0 = n_reads;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(poke ? "R10 no late done" : "R9 no done", 32'(done | err), 32'd0);
            end
            chk(poke ? "R10 no extra read" : "R9 no read", 32'(n_reads), 32'(rd0));
            chk(poke ? "R10 acc kept" : "R9 acc kept", 32'(acc), 32'(expv));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'h1C0FFEE));
        repeat (4) @(negedge clk);
        chk("R1 acc", 32'(acc), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 mem_rd", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;

        // Directed corner cases
        run_op(3'd0, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R2
        run_op(3'd1, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R3
        run_op(3'd2, 12'd10, 12'd20, 16'hBEEF, 12'd30, 1'b0); // R4 full width
        run_op(3'd3, 12'd10, 12'd20, 16'hF00A, 12'd30, 1'b0); // R5 upper bits dropped
        run_op(3'd4, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R6
        run_op(3'd5, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R7 reads 32
        run_op(3'd5, 12'hF05, 12'd750, 16'd0, 12'd0, 1'b0);   // R7 offset -251
        run_op(3'd5, 12'd0, 12'hFFF, 16'd0, 12'd0, 1'b0);     // R7 wrap
        run_op(3'd6, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R8 reads 40
        run_op(3'd6, 12'd4000, 12'd0, 16'd0, 12'd200, 1'b0);  // R8 wrap
        run_op(3'd7, 12'd10, 12'd20, 16'd10, 12'd30, 1'b0);   // R9
        run_op(3'd0, 12'd77, 12'd5, 16'd1, 12'd2, 1'b1);      // R10
        run_op(3'd1, 12'd99, 12'd5, 16'd1, 12'd2, 1'b1);      // R10 during two reads

        // Random mix
        for (int i = 0; i < 80; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            run_op(m, AW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom),
                   (m != 3'd2 && m != 3'd7) && ($urandom % 4 == 0));
        end
        finish_up();
    end

endmodule